// File: doc/BRIEF.md
# Boot-time SPI register loader for clock devices

This block brings up a set of clock devices once the chip leaves reset. On a start pulse it walks a region of a byte-addressed EEPROM and reads register-write records, each made of a register address byte and a data byte. Every record it reads becomes one 16-bit SPI write to one of three slave devices. The devices are served one after another, and only the chip select of the device being written goes low.

Each device owns several alternative configuration blocks in the EEPROM. A switch input picks which block is used, and the block samples the switch when the start pulse arrives. A block holds a fixed number of records. An address byte of 0xFF ends that device's list early. Apart from that end marker, bytes are forwarded exactly as read, with no check that a register address or value is valid. Two outputs report progress: `busy` covers the whole sequence and `done` stays high once the sequence is complete.

Top module: `cfg_spi_seq`

## Requirements
- R1: While reset is held and after its release, busy, done, ee_req and spi_sclk are low and every spi_cs_n bit is high.
- R2: A start pulse seen while busy is low raises busy on the next clock edge and clears done. A start pulse or a cfg_sel change seen while busy is high has no effect on the writes that are produced.
- R3: The address byte of record r for device d is read from EEPROM byte BASE + (d*CFGS + s)*(2*RECS) + 2*r, and its data byte from the next address. BASE defaults to 15000 and s is the cfg_sel value captured at start. Every request falls inside that region.
- R4: Each SPI write is 16 bits sent MSB first: the address byte in bits 15..8, then the data byte in bits 7..0. spi_sclk idles low, spi_mosi is set up while spi_sclk is low, and the slave samples it on the rising edge.
- R5: Exactly one spi_cs_n bit, the one for the device being written, is low for the whole of a frame, and it covers all 16 clock pulses. Between two frames every chip select stays high for at least one spi_sclk period (2*HALF clock cycles).
- R6: The devices are configured in the fixed order 0, 1, 2, and the records of one device are written in increasing record order.
- R7: A record whose address byte is 0xFF is not sent. It ends that device's list, and the sequence moves on to the next device.
- R8: A device whose block holds no 0xFF address byte gets exactly RECS writes.
- R9: Any address byte other than 0xFF, and any data byte including 0xFF, is written over SPI unchanged.
- R10: After the last device is finished, done goes high and busy goes low. done stays high until the next start pulse.
- R11: ee_req stays high with a stable ee_addr until ee_ack is seen, and ee_rdata is taken in the cycle in which ee_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle pulse that begins a sequence |
| cfg_sel | input | SW_W | Switch setting that selects the configuration block |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | High from the end of a sequence until the next start |
| ee_req | output | 1 | EEPROM byte-read request, held until acknowledged |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_ack | input | 1 | Single-cycle read acknowledge |
| ee_rdata | input | 8 | Read data, valid while ee_ack is high |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | NUM_DEV | Active-low chip selects, one per device |

## Verification
The assertions assume that cfg_sel stays below the number of configurations per device whenever start is pulsed. They also assume that ee_ack arrives only as a single-cycle reply to a pending request. The bench's EEPROM model answers only an open request, after a random latency of zero to two cycles, and never acknowledges twice in a row. The bench draws switch values only from the legal range, including when it changes the switch during a run. It fills the record region with random bytes, but adds an end marker only where a test places one on purpose.

// File: rtl/cfg_spi_seq_pkg.sv
// Shared constants and types for the EEPROM-to-SPI configuration loader.
// Assumes 8-bit register addresses and data bytes.
package cfg_spi_seq_pkg;

    localparam int          FRAME_BITS = 16;
    localparam int          BITN_W     = $clog2(FRAME_BITS);
    localparam logic [7:0]  END_MARK   = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_RD_DATA,
        SQ_EVAL,
        SQ_LAUNCH,
        SQ_WAIT_TX,
        SQ_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SHIFT,
        TX_GAP
    } tx_state_t;

    typedef struct packed {
        logic [7:0] reg_addr;
        logic [7:0] reg_data;
    } reg_write_t;

endpackage

// File: rtl/cfg_ee_addr.sv
// Computes the EEPROM byte address of the current record byte.
// Assumes sel < CFGS and that the whole region fits in EE_AW bits.
module cfg_ee_addr #(
    parameter int BASE  = 15000,
    parameter int CFGS  = 4,
    parameter int RECS  = 8,
    parameter int EE_AW = 16,
    parameter int DEV_W = 2,
    parameter int REC_W = 3,
    parameter int SW_W  = 2
) (
    input  logic [DEV_W-1:0] dev,
    input  logic [SW_W-1:0]  sel,
    input  logic [REC_W-1:0] rec,
    input  logic             byte_sel,
    output logic [EE_AW-1:0] addr
);
    localparam int BLK_BYTES = 2 * RECS;

    logic [31:0] offset;

    // Block offset from device and switch, then record and byte within it.
    always_comb begin
        offset = (32'(dev) * 32'(CFGS) + 32'(sel)) * 32'(BLK_BYTES)
               + 32'(rec) * 32'd2 + 32'(byte_sel);
        addr   = EE_AW'(32'(BASE) + offset);
    end

endmodule

// File: rtl/cfg_seq_fsm.sv
// Sequencing control: reads records byte by byte, stops a device's list
// at the end marker or after RECS records, and hands records to the
// SPI writer. Assumes ee_ack only answers a pending request.
module cfg_seq_fsm
    import cfg_spi_seq_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int RECS    = 8,
    parameter int DEV_W   = 2,
    parameter int REC_W   = 3,
    parameter int SW_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SW_W-1:0]  cfg_sel,
    input  logic             ee_ack,
    input  logic [7:0]       ee_rdata,
    input  logic             tx_done,
    output logic             busy,
    output logic             done,
    output logic             ee_req,
    output logic             byte_sel,
    output logic [DEV_W-1:0] dev_idx,
    output logic [REC_W-1:0] rec_idx,
    output logic [SW_W-1:0]  sel_q,
    output logic             tx_go,
    output reg_write_t       tx_rec
);
    seq_state_t st;
    logic       last_dev;
    logic       last_rec;

    assign last_dev = (dev_idx == DEV_W'(NUM_DEV - 1));
    assign last_rec = (rec_idx == REC_W'(RECS - 1));
    assign ee_req   = (st == SQ_RD_ADDR) || (st == SQ_RD_DATA);
    assign byte_sel = (st == SQ_RD_DATA);
    assign tx_go    = (st == SQ_LAUNCH);

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            busy    <= 1'b0;
            done    <= 1'b0;
            dev_idx <= '0;
            rec_idx <= '0;
            sel_q   <= '0;
            tx_rec  <= '0;
        end else begin
            case (st)
                SQ_IDLE, SQ_FINISH: begin
                    if (start) begin
                        sel_q   <= cfg_sel;
                        dev_idx <= '0;
                        rec_idx <= '0;
                        busy    <= 1'b1;
                        done    <= 1'b0;
                        st      <= SQ_RD_ADDR;
                    end
                end
                SQ_RD_ADDR: begin
                    if (ee_ack) begin
                        tx_rec.reg_addr <= ee_rdata;
                        st              <= SQ_RD_DATA;
                    end
                end
                SQ_RD_DATA: begin
                    if (ee_ack) begin
                        tx_rec.reg_data <= ee_rdata;
                        st              <= SQ_EVAL;
                    end
                end
                SQ_EVAL: begin
                    if (tx_rec.reg_addr != END_MARK) begin
                        st <= SQ_LAUNCH;
                    end else if (last_dev) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        st   <= SQ_FINISH;
                    end else begin
                        dev_idx <= dev_idx + 1'b1;
                        rec_idx <= '0;
                        st      <= SQ_RD_ADDR;
                    end
                end
                SQ_LAUNCH: begin
                    st <= SQ_WAIT_TX;
                end
                SQ_WAIT_TX: begin
                    if (tx_done) begin
                        if (!last_rec) begin
                            rec_idx <= rec_idx + 1'b1;
                            st      <= SQ_RD_ADDR;
                        end else if (last_dev) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                            st   <= SQ_FINISH;
                        end else begin
                            dev_idx <= dev_idx + 1'b1;
                            rec_idx <= '0;
                            st      <= SQ_RD_ADDR;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_wr_tx.sv
// Sends one 16-bit write frame, MSB first, with the clock idling low
// and data sampled by the slave on the rising edge. After the frame it
// keeps every select high for one full SCLK period, then pulses done.
// Assumes go is raised only while the writer is idle.
module spi_wr_tx
    import cfg_spi_seq_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int DEV_W   = 2,
    parameter int HALF    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [DEV_W-1:0]   dev,
    input  reg_write_t         word,
    output logic               sclk,
    output logic               mosi,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               done
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

    tx_state_t                 st;
    logic [DIV_W-1:0]          div;
    logic                      phase;
    logic [BITN_W-1:0]         bitn;
    logic [FRAME_BITS-1:0]     shreg;
    logic [DEV_W-1:0]          dev_q;
    logic                      tick;

    assign tick = (div == DIV_W'(HALF - 1));
    assign mosi = (st == TX_SHIFT) ? shreg[FRAME_BITS-1] : 1'b0;

    // One active-low select per device, low only while shifting to it.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
        assign cs_n[g] = !((st == TX_SHIFT) && (dev_q == DEV_W'(g)));
    end

    // Bit timing, shifting and inter-frame gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            div   <= '0;
            phase <= 1'b0;
            bitn  <= '0;
            shreg <= '0;
            dev_q <= '0;
            sclk  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                TX_IDLE: begin
                    div   <= '0;
                    phase <= 1'b0;
                    if (go) begin
                        shreg <= word;
                        dev_q <= dev;
                        bitn  <= '0;
                        st    <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (!tick) begin
                        div <= div + 1'b1;
                    end else begin
                        div <= '0;
                        if (!phase) begin
                            sclk  <= 1'b1;
                            phase <= 1'b1;
                        end else begin
                            sclk  <= 1'b0;
                            phase <= 1'b0;
                            if (bitn == BITN_W'(FRAME_BITS - 1)) begin
                                st <= TX_GAP;
                            end else begin
                                bitn  <= bitn + 1'b1;
                                shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                TX_GAP: begin
                    if (!tick) begin
                        div <= div + 1'b1;
                    end else begin
                        div <= '0;
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            done  <= 1'b1;
                            st    <= TX_IDLE;
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_spi_seq.sv
// Top level: runs once per start pulse, reads the switch-selected record
// blocks from EEPROM and writes them to NUM_DEV SPI slaves in order.
// Assumes cfg_sel < CFGS at start and an EEPROM port with req/ack.
module cfg_spi_seq
    import cfg_spi_seq_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int CFGS    = 4,
    parameter int RECS    = 8,
    parameter int BASE    = 15000,
    parameter int EE_AW   = 16,
    parameter int HALF    = 2,
    parameter int SW_W    = (CFGS > 1) ? $clog2(CFGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SW_W-1:0]    cfg_sel,
    output logic               busy,
    output logic               done,
    output logic               ee_req,
    output logic [EE_AW-1:0]   ee_addr,
    input  logic               ee_ack,
    input  logic [7:0]         ee_rdata,
    output logic               spi_sclk,
    output logic               spi_mosi,
    output logic [NUM_DEV-1:0] spi_cs_n
);
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int REC_W = (RECS > 1) ? $clog2(RECS) : 1;

    logic             byte_sel;
    logic [DEV_W-1:0] dev_idx;
    logic [REC_W-1:0] rec_idx;
    logic [SW_W-1:0]  sel_q;
    logic             tx_go;
    logic             tx_done;
    reg_write_t       tx_rec;

    cfg_seq_fsm #(
        .NUM_DEV (NUM_DEV),
        .RECS    (RECS),
        .DEV_W   (DEV_W),
        .REC_W   (REC_W),
        .SW_W    (SW_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_sel  (cfg_sel),
        .ee_ack   (ee_ack),
        .ee_rdata (ee_rdata),
        .tx_done  (tx_done),
        .busy     (busy),
        .done     (done),
        .ee_req   (ee_req),
        .byte_sel (byte_sel),
        .dev_idx  (dev_idx),
        .rec_idx  (rec_idx),
        .sel_q    (sel_q),
        .tx_go    (tx_go),
        .tx_rec   (tx_rec)
    );

    cfg_ee_addr #(
        .BASE  (BASE),
        .CFGS  (CFGS),
        .RECS  (RECS),
        .EE_AW (EE_AW),
        .DEV_W (DEV_W),
        .REC_W (REC_W),
        .SW_W  (SW_W)
    ) u_addr (
        .dev      (dev_idx),
        .sel      (sel_q),
        .rec      (rec_idx),
        .byte_sel (byte_sel),
        .addr     (ee_addr)
    );

    spi_wr_tx #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W),
        .HALF    (HALF)
    ) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (tx_go),
        .dev  (dev_idx),
        .word (tx_rec),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .cs_n (spi_cs_n),
        .done (tx_done)
    );

endmodule

// File: rtl/cfg_spi_seq_chk.sv
// Property checker for cfg_spi_seq, attached by bind below.
// Assumes cfg_sel is legal when start is pulsed.
module cfg_spi_seq_chk #(
    parameter int NUM_DEV = 3,
    parameter int CFGS    = 4,
    parameter int RECS    = 8,
    parameter int BASE    = 15000,
    parameter int EE_AW   = 16,
    parameter int SW_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [SW_W-1:0]    cfg_sel,
    input logic               busy,
    input logic               done,
    input logic               ee_req,
    input logic [EE_AW-1:0]   ee_addr,
    input logic               ee_ack,
    input logic               spi_sclk,
    input logic               spi_mosi,
    input logic [NUM_DEV-1:0] spi_cs_n
);
    localparam int REGION = NUM_DEV * CFGS * 2 * RECS;

    // Outputs are quiet while reset is applied.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (!busy && !done && !ee_req && !spi_sclk && (&spi_cs_n))
                else $error("outputs active during reset");
        end
    end

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    assert_sel_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (32'(cfg_sel) < 32'(CFGS)));

    assert_addr_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |-> ((ee_addr >= EE_AW'(BASE)) && (ee_addr < EE_AW'(BASE + REGION))));

    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    assert_select_under_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> ($countones(~spi_cs_n) == 1));

    assert_busy_done_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

endmodule

bind cfg_spi_seq cfg_spi_seq_chk #(
    .NUM_DEV (NUM_DEV),
    .CFGS    (CFGS),
    .RECS    (RECS),
    .BASE    (BASE),
    .EE_AW   (EE_AW),
    .SW_W    (SW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_sel  (cfg_sel),
    .busy     (busy),
    .done     (done),
    .ee_req   (ee_req),
    .ee_addr  (ee_addr),
    .ee_ack   (ee_ack),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n)
);

// File: tb/cfg_spi_seq_bench.sv
// Bench: behavioural EEPROM, three SPI slave monitors, expected writes
// computed from the EEPROM image and the switch value.
module cfg_spi_seq_bench;
    localparam int NUM_DEV = 3;
    localparam int CFGS    = 4;
    localparam int RECS    = 8;
    localparam int BASE    = 15000;
    localparam int EE_AW   = 16;
    localparam int HALF    = 2;
    localparam int BLK     = 2 * RECS;
    localparam int MEM_SZ  = NUM_DEV * CFGS * BLK;
    localparam int LOG_SZ  = 1024;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         cfg_sel = '0;
    logic               busy, done, ee_req, ee_ack;
    logic [EE_AW-1:0]   ee_addr;
    logic [7:0]         ee_rdata;
    logic               spi_sclk, spi_mosi;
    logic [NUM_DEV-1:0] spi_cs_n;

    always #5 clk = ~clk;

    cfg_spi_seq #(
        .NUM_DEV(NUM_DEV), .CFGS(CFGS), .RECS(RECS),
        .BASE(BASE), .EE_AW(EE_AW), .HALF(HALF)
    ) u_cfg_spi_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_sel(cfg_sel),
        .busy(busy), .done(done), .ee_req(ee_req), .ee_addr(ee_addr),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    logic [7:0]  mem [0:MEM_SZ-1];
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;

    // Behavioural EEPROM with random 0..2 cycle latency.
    int lat = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ee_ack   <= 1'b0;
            ee_rdata <= '0;
            lat      <= 0;
        end else if (ee_req && !ee_ack) begin
            if (lat == 0) begin
                ee_ack <= 1'b1;
                if (int'(ee_addr) >= BASE && int'(ee_addr) < BASE + MEM_SZ)
                    ee_rdata <= mem[int'(ee_addr) - BASE];
                else
                    ee_rdata <= 8'h00;
                lat <= int'($urandom % 3);
            end else begin
                lat <= lat - 1;
            end
        end else begin
            ee_ack <= 1'b0;
        end
    end

    // SPI slave monitors and protocol bookkeeping, sampled mid-cycle.
    int          log_dev [0:LOG_SZ-1];
    logic [15:0] log_word [0:LOG_SZ-1];
    int          log_n = 0;
    logic [15:0] sh [0:NUM_DEV-1];
    int          nbits [0:NUM_DEV-1];
    int          bits_err = 0, gap_err = 0, cs_err = 0, range_err = 0, req_err = 0;
    int          gap_cnt = 1000;
    logic        p_sclk = 1'b0, p_req = 1'b0, p_ack = 1'b0;
    logic [NUM_DEV-1:0] p_cs = '1;
    logic [EE_AW-1:0]   p_addr = '0;

    initial begin
        for (int d = 0; d < NUM_DEV; d++) begin
            sh[d] = '0;
            nbits[d] = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(~spi_cs_n) > 1) cs_err++;
            if ((&p_cs) && !(&spi_cs_n)) begin
                if (gap_cnt < 2 * HALF) gap_err++;
                gap_cnt = 0;
            end
            if (&spi_cs_n) gap_cnt++;
            for (int d = 0; d < NUM_DEV; d++) begin
                if (!spi_cs_n[d] && spi_sclk && !p_sclk) begin
                    sh[d] = {sh[d][14:0], spi_mosi};
                    nbits[d]++;
                end
                if (spi_cs_n[d] && !p_cs[d]) begin
                    if (nbits[d] != 16) bits_err++;
                    if (log_n < LOG_SZ) begin
                        log_dev[log_n]  = d;
                        log_word[log_n] = sh[d];
                    end
                    log_n++;
                    nbits[d] = 0;
                end
            end
            if (spi_sclk && (&spi_cs_n)) cs_err++;
            if (ee_req && (int'(ee_addr) < BASE || int'(ee_addr) >= BASE + MEM_SZ)) range_err++;
            if (p_req && !p_ack && (!ee_req || ee_addr != p_addr)) req_err++;
        end
        p_sclk = spi_sclk;
        p_cs   = spi_cs_n;
        p_req  = ee_req;
        p_ack  = ee_ack;
        p_addr = ee_addr;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected write list for switch value s (R3, R6, R7, R8, R9).
    int          exp_dev [0:NUM_DEV*RECS-1];
    logic [15:0] exp_word [0:NUM_DEV*RECS-1];
    int          exp_n;

    task automatic build_expected(input int s);
        exp_n = 0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int r = 0; r < RECS; r++) begin
                int base_i = (d * CFGS + s) * BLK + 2 * r;
                if (mem[base_i] == 8'hFF) break;
                exp_dev[exp_n]  = d;
                exp_word[exp_n] = {mem[base_i], mem[base_i + 1]};
                exp_n++;
            end
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < MEM_SZ; i++) begin
            if (i % 2 == 0) mem[i] = 8'($urandom % 255);
            else            mem[i] = 8'($urandom);
        end
    endtask

    task automatic put_end(input int d, input int s, input int r);
        mem[(d * CFGS + s) * BLK + 2 * r] = 8'hFF;
    endtask

    task automatic do_run(input int s, input bit noise);
        int base_log, e_bits, e_gap, e_cs, e_rng, e_req, waited;
        build_expected(s);
        base_log = log_n;
        e_bits = bits_err; e_gap = gap_err; e_cs = cs_err;
        e_rng = range_err; e_req = req_err;
        @(negedge clk);
        cfg_sel = 2'(s);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk(busy && !done, "R2 busy after start", {busy, done}, 2);
        if (noise) begin
            repeat (60) @(negedge clk);
            cfg_sel = 2'((s + 1) % CFGS);
            start   = 1'b1;   // R2: ignored while busy
            @(negedge clk);
            start   = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done && !busy, "R10 done at end", {busy, done}, 1);
        repeat (10) @(negedge clk);
        chk(done && !busy, "R10 done held", {busy, done}, 1);
        chk(log_n - base_log == exp_n, "R7 R8 write count", log_n - base_log, exp_n);
        for (int i = 0; i < exp_n && i < log_n - base_log; i++) begin
            chk(log_dev[base_log + i] == exp_dev[i], "R6 device order",
                log_dev[base_log + i], exp_dev[i]);
            chk(log_word[base_log + i] == exp_word[i], "R4 R9 frame content",
                int'(log_word[base_log + i]), int'(exp_word[i]));
        end
        chk(bits_err == e_bits && cs_err == e_cs, "R5 select framing",
            bits_err - e_bits + cs_err - e_cs, 0);
        chk(gap_err == e_gap, "R5 inter-frame gap", gap_err - e_gap, 0);
        chk(range_err == e_rng, "R3 request range", range_err - e_rng, 0);
        chk(req_err == e_req, "R11 request held", req_err - e_req, 0);
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ee_req && !spi_sclk && (&spi_cs_n), "R1 reset state",
            {busy, done, ee_req, spi_sclk}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ee_req && (&spi_cs_n), "R1 idle after reset",
            {busy, done, ee_req}, 0);

        // R8: full lists on every device, switch 0.
        fill_random();
        do_run(0, 1'b0);

        // R7, R9: empty list on device 1, marker on last record of device 2,
        // 0xFF data bytes and zero address on device 0.
        fill_random();
        put_end(1, 2, 0);
        put_end(2, 2, RECS - 1);
        mem[(0 * CFGS + 2) * BLK + 1] = 8'hFF;
        mem[(0 * CFGS + 2) * BLK + 3] = 8'hFF;
        mem[(0 * CFGS + 2) * BLK + 4] = 8'h00;
        do_run(2, 1'b0);

        // R7: all devices empty.
        fill_random();
        for (int d = 0; d < NUM_DEV; d++) put_end(d, 3, 0);
        do_run(3, 1'b0);

        // Random blocks, random markers, some runs with a start and a
        // switch change while busy (R2).
        for (int k = 0; k < 6; k++) begin
            int s;
            fill_random();
            s = int'($urandom % CFGS);
            for (int d = 0; d < NUM_DEV; d++)
                if ($urandom % 2 == 1) put_end(d, s, int'($urandom % RECS));
            do_run(s, k % 2 == 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule